// File: doc/BRIEF.md
# Layer Alpha Blending Stage

This stage lays one overlay layer over a background pixel stream. For each pixel it takes a background colour, a layer colour, a raw layer alpha and a code giving how many bits that alpha has. A per-layer control word decides what happens. The layer can be switched off, so that the background passes through. The alpha can come from each pixel or from one constant for the whole plane, or the layer can be fully opaque. The layer colour can be weighted by alpha, which is coverage blending, or taken as already weighted, which is premultiplied blending.

Narrow alpha channels of 1 or 2 bits are widened to 8 bits through a programmable word that holds four alpha levels. A typical setting holds 0%, 33%, 66% and 100% opacity (0x00, 0x55, 0xAA, 0xFF). The datapath is a fixed two-stage pipeline. The control word and the lookup word are sampled together with the pixel, so they can change from one pixel to the next.

Pixels carry `NCH` channels of 8 bits. Channel c occupies bits [8c+7:8c].

Top module: `layer_blend`

## Requirements
- R1: The control word fields are: bit 0 enables the layer, bits 13:12 give the composition mode, bit 14 selects premultiplied blending, and bits 23:16 hold the plane alpha.
- R2: Mode 3 uses the per-pixel alpha. Mode 2 uses the plane alpha. Modes 0 and 1 treat the layer as opaque, with alpha 255, so an enabled opaque layer outputs the layer pixel.
- R3: The alpha width code works as follows. Code 0 uses `ly_alpha` directly. Code 1 uses `ly_alpha[0]`, where 0 selects lookup entry 0 and 1 selects entry 3. Code 2 uses `ly_alpha[1:0]` as the entry index. Code 3 means the format has no alpha channel and gives 255. Entry k sits in bits [8k+7:8k] of `alpha_lut`.
- R4: In coverage mode (bit 14 = 0), each channel is (L*a + B*(255-a) + 127)/255, using integer division.
- R5: In premultiplied mode (bit 14 = 1), each channel is L + (B*(255-a) + 127)/255, saturated at 255.
- R6: With the layer disabled, the output pixel equals the background pixel. The layer pixel, the alpha and the other control fields have no effect.
- R7: `out_valid` is asserted exactly 2 cycles after an input cycle in which `bg_valid` is high and either `ly_valid` is high or the layer is disabled. `out_pixel` belongs to that same input cycle, and back-to-back pixels stream at one per cycle.
- R8: While reset is asserted and after it is released, `out_valid` and `out_pixel` are 0 until valid input has travelled through the pipeline.
- R9: In plane-alpha mode, the per-pixel alpha value and its width code have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 32 | Layer control word |
| alpha_lut | input | 32 | Four 8-bit alpha levels for narrow alpha |
| bg_valid | input | 1 | Background pixel valid |
| bg_pixel | input | 8*NCH | Background pixel |
| ly_valid | input | 1 | Layer pixel valid |
| ly_pixel | input | 8*NCH | Layer pixel |
| ly_alpha | input | 8 | Raw layer alpha |
| ly_alpha_width | input | 2 | Alpha width code |
| out_valid | output | 1 | Blended pixel valid |
| out_pixel | output | 8*NCH | Blended pixel |

## Verification
The blend is driven with a table that crosses every composition mode with both blend styles and every alpha width code.

The two lookup-word contents tell a real lookup apart from a fixed expansion. Alpha values of 0, midrange and full separate the rounding of the coverage formula from the saturation of the premultiplied one.

Plane-alpha cases carry conflicting pixel alpha, which shows that the pixel alpha has been ignored. Disabled cases carry a saturated layer pixel, which shows that the output is a pure bypass.

Directed runs cover the streaming timing and the gating of valid by the layer-valid flag.

// File: rtl/layer_blend.sv
module layer_blend #(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl,
  input  logic [31:0]       alpha_lut,
  input  logic              bg_valid,
  input  logic [8*NCH-1:0]  bg_pixel,
  input  logic              ly_valid,
  input  logic [8*NCH-1:0]  ly_pixel,
  input  logic [7:0]        ly_alpha,
  input  logic [1:0]        ly_alpha_width,
  output logic              out_valid,
  output logic [8*NCH-1:0]  out_pixel
);
  localparam int PW = 8*NCH;

  logic       en, pmul;
  logic [1:0] mode;
  logic [7:0] plane_a, px_a, eff_a;
  logic       unused_ctrl;

  assign en      = ctrl[0];
  assign mode    = ctrl[13:12];
  assign pmul    = ctrl[14];
  assign plane_a = ctrl[23:16];
  assign unused_ctrl = ^{ctrl[31:24], ctrl[15], ctrl[11:1]};

  always_comb begin
    case (ly_alpha_width)
      2'd0:    px_a = ly_alpha;
      2'd1:    px_a = ly_alpha[0] ? alpha_lut[31:24] : alpha_lut[7:0];
      2'd2:    px_a = alpha_lut[8*ly_alpha[1:0] +: 8];
      default: px_a = 8'hff;
    endcase
  end

  assign eff_a = (mode == 2'd3) ? px_a :
                 (mode == 2'd2) ? plane_a : 8'hff;

  logic          s1_v, s1_en, s1_pm;
  logic [7:0]    s1_a;
  logic [PW-1:0] s1_bg, s1_ly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_en <= 1'b0;
      s1_pm <= 1'b0;
      s1_a  <= '0;
      s1_bg <= '0;
      s1_ly <= '0;
    end else begin
      s1_v  <= bg_valid & (ly_valid | ~en);
      s1_en <= en;
      s1_pm <= pmul;
      s1_a  <= eff_a;
      s1_bg <= bg_pixel;
      s1_ly <= ly_pixel;
    end
  end

  logic [7:0]    inv_a;
  logic [PW-1:0] res;
  assign inv_a = 8'd255 - s1_a;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0]  l, b, cov, bpart;
    logic [16:0] lw, bw, csum, bsum;
    logic [8:0]  pm;
    assign l     = s1_ly[8*c +: 8];
    assign b     = s1_bg[8*c +: 8];
    assign lw    = 17'(l) * 17'(s1_a);
    assign bw    = 17'(b) * 17'(inv_a);
    assign csum  = lw + bw + 17'd127;
    assign bsum  = bw + 17'd127;
    assign cov   = 8'(csum / 17'd255);
    assign bpart = 8'(bsum / 17'd255);
    assign pm    = {1'b0, l} + {1'b0, bpart};
    assign res[8*c +: 8] = !s1_en ? b :
                           s1_pm  ? (pm[8] ? 8'hff : pm[7:0]) : cov;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= s1_v;
      out_pixel <= res;
    end
  end
endmodule

// File: rtl/layer_blend_chk.sv
module layer_blend_chk #(
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl,
  input logic             bg_valid,
  input logic [8*NCH-1:0] bg_pixel,
  input logic             ly_valid,
  input logic [8*NCH-1:0] ly_pixel,
  input logic             out_valid,
  input logic [8*NCH-1:0] out_pixel
);
  logic [1:0] age;
  logic       warm;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end
  assign warm = (age == 2'd2);

  assert_reset_idle_R8: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> out_valid == $past(bg_valid && (ly_valid || !ctrl[0]), 2));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !$past(ctrl[0], 2)) |-> out_pixel == $past(bg_pixel, 2));

  assert_opaque_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(ctrl[0] && !ctrl[13], 2)) |-> out_pixel == $past(ly_pixel, 2));

  assert_plane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(ctrl[0] && ctrl[13:12] == 2'd2 && !ctrl[14] && ctrl[23:16] == 8'd0, 2))
      |-> out_pixel == $past(bg_pixel, 2));

  for (genvar c = 0; c < NCH; c++) begin : g_pm
    assert_premul_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(ctrl[0] && ctrl[14], 2))
        |-> out_pixel[8*c +: 8] >= $past(ly_pixel[8*c +: 8], 2));
  end
endmodule

bind layer_blend layer_blend_chk #(.NCH(NCH)) i_chk (.*);

// File: tb/test_layer_blend.sv
module test_layer_blend;
  localparam int NCH = 3;
  localparam int PW  = 8*NCH;
  localparam int VW  = 32 + 32 + PW + PW + 8 + 2;
  localparam int NV  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ctrl = '0, alpha_lut = '0;
  logic bg_valid = 1'b0, ly_valid = 1'b0;
  logic [PW-1:0] bg_pixel = '0, ly_pixel = '0;
  logic [7:0] ly_alpha = '0;
  logic [1:0] ly_alpha_width = '0;
  logic out_valid;
  logic [PW-1:0] out_pixel;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  layer_blend #(.NCH(NCH)) i_layer_blend (.*);

  // {ctrl, lut, bg, ly, alpha, width}
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0000_3000, 32'hffaa5500, 24'h123456, 24'hffffff, 8'hff, 2'd0}, // R6 disabled
    {32'h0000_0001, 32'hffaa5500, 24'h102030, 24'ha0b0c0, 8'h00, 2'd0}, // R2 opaque
    {32'h0000_3001, 32'hffaa5500, 24'h102030, 24'hf0e0d0, 8'h80, 2'd0}, // R4 8-bit
    {32'h0000_3001, 32'hffaa5500, 24'h102030, 24'hf0e0d0, 8'h00, 2'd0}, // R4 a=0
    {32'h0000_3001, 32'hffaa5500, 24'h00ff00, 24'h336699, 8'h01, 2'd1}, // R3 1-bit one
    {32'h0000_3001, 32'hffaa5500, 24'h00ff00, 24'h336699, 8'hfe, 2'd1}, // R3 1-bit zero
    {32'h0000_3001, 32'hffaa5500, 24'h000000, 24'hffffff, 8'h01, 2'd2}, // R3 2-bit idx1
    {32'h0000_3001, 32'h40302010, 24'h804020, 24'h20c0ff, 8'h02, 2'd2}, // R3 custom lut
    {32'h0000_3001, 32'h40302010, 24'h804020, 24'h20c0ff, 8'h00, 2'd3}, // R3 no alpha
    {32'h0040_2001, 32'hffaa5500, 24'hffffff, 24'h000000, 8'h00, 2'd0}, // R9 plane
    {32'h0000_2001, 32'hffaa5500, 24'h445566, 24'hffffff, 8'hff, 2'd3}, // R9 plane zero
    {32'h0000_7001, 32'hffaa5500, 24'hffffff, 24'h909090, 8'h80, 2'd0}, // R5 saturate
    {32'h0000_7001, 32'hffaa5500, 24'h202020, 24'h101010, 8'h00, 2'd0}, // R5 a=0
    {32'h00ff_6001, 32'hffaa5500, 24'hffffff, 24'h112233, 8'h00, 2'd0}, // R5 plane full
    {32'h0000_5001, 32'hffaa5500, 24'h777777, 24'h123456, 8'h00, 2'd0}, // R1 mode1 opaque
    {32'h0000_3001, 32'hffaa5500, 24'h00ff80, 24'hff0080, 8'hc0, 2'd0}  // R4 mixed
  };

  function automatic logic [7:0] ref_alpha(logic [31:0] c, logic [31:0] lut,
                                           logic [7:0] a, logic [1:0] w);
    logic [7:0] p;
    case (w)
      2'd0: p = a;
      2'd1: p = a[0] ? lut[31:24] : lut[7:0];
      2'd2: p = lut[8*a[1:0] +: 8];
      default: p = 8'hff;
    endcase
    if (c[13:12] == 2'd3) return p;
    if (c[13:12] == 2'd2) return c[23:16];
    return 8'hff;
  endfunction

  function automatic logic [PW-1:0] ref_blend(logic [VW-1:0] v);
    logic [31:0] c; logic [31:0] lut; logic [PW-1:0] b, l, r;
    logic [7:0] a;
    {c, lut, b, l} = v[VW-1:10];
    a = ref_alpha(c, lut, v[9:2], v[1:0]);
    for (int k = 0; k < NCH; k++) begin
      int lc, bc, t;
      lc = int'(l[8*k +: 8]); bc = int'(b[8*k +: 8]);
      if (!c[0]) t = bc;
      else if (c[14]) begin
        t = lc + (bc*(255-int'(a)) + 127)/255;
        if (t > 255) t = 255;
      end else t = (lc*int'(a) + bc*(255-int'(a)) + 127)/255;
      r[8*k +: 8] = 8'(t);
    end
    return r;
  endfunction

  task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [VW-1:0] v, logic bv, logic lv);
    {ctrl, alpha_lut, bg_pixel, ly_pixel, ly_alpha, ly_alpha_width} = v;
    bg_valid = bv; ly_valid = lv;
  endtask

  task automatic idle();
    bg_valid = 1'b0; ly_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", PW'(out_valid), PW'(1'b0));
    check("R8 reset pixel", out_pixel, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", PW'(out_valid), PW'(1'b0));

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1, 1'b1);
      @(negedge clk); idle();
      @(negedge clk);
      check($sformatf("R7 valid vec%0d", i), PW'(out_valid), PW'(1'b1));
      check($sformatf("R4/R5 pixel vec%0d", i), out_pixel, ref_blend(VEC[i]));
      @(negedge clk);
      check($sformatf("R7 single pulse vec%0d", i), PW'(out_valid), PW'(1'b0));
    end

    // R4 hand value: a=0x55, L=ff, B=00 -> 0x55
    drive({32'h0000_3001, 32'hffaa5500, 24'h000000, 24'hffffff, 8'h55, 2'd0}, 1'b1, 1'b1);
    @(negedge clk); idle(); @(negedge clk);
    check("R4 rounding 0x55", out_pixel, 24'h555555);

    // R5 hand value: 0xc8 + 0xc8 saturates
    drive({32'h0000_7001, 32'hffaa5500, 24'hc8c8c8, 24'hc8c8c8, 8'h00, 2'd0}, 1'b1, 1'b1);
    @(negedge clk); idle(); @(negedge clk);
    check("R5 saturate", out_pixel, 24'hffffff);

    // R7 layer not valid while enabled -> no output
    drive(VEC[2], 1'b1, 1'b0);
    @(negedge clk); idle(); @(negedge clk);
    check("R7 gated by ly_valid", PW'(out_valid), PW'(1'b0));

    // R6 disabled passes even without layer valid
    drive(VEC[0], 1'b1, 1'b0);
    @(negedge clk); idle(); @(negedge clk);
    check("R6 disabled valid", PW'(out_valid), PW'(1'b1));
    check("R6 disabled pixel", out_pixel, 24'h123456);

    // R7 back-to-back streaming, control changes per pixel
    drive(VEC[4], 1'b1, 1'b1);
    @(negedge clk); drive(VEC[11], 1'b1, 1'b1);
    @(negedge clk); idle();
    check("R7 stream first", out_pixel, ref_blend(VEC[4]));
    @(negedge clk);
    check("R7 stream second valid", PW'(out_valid), PW'(1'b1));
    check("R7 stream second", out_pixel, ref_blend(VEC[11]));

    // R9 plane mode: changing pixel alpha/width changes nothing
    drive({32'h0080_2001, 32'hffaa5500, 24'h000000, 24'hfefefe, 8'h00, 2'd1}, 1'b1, 1'b1);
    @(negedge clk); idle(); @(negedge clk);
    check("R9 ignores pixel alpha", out_pixel, 24'h7f7f7f);

    // R8 reset in flight clears pipeline
    drive(VEC[1], 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b0; idle();
    @(negedge clk);
    check("R8 reset flush", PW'(out_valid), PW'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule